// File: doc/BRIEF.md
# Receive Address Match Filter

This block sits between a character receiver and a receive FIFO and decides, character by character, whether a received data character may be written into the FIFO. The received stream carries serial address commands. Each command opens an operation, and the data characters that follow it belong to that operation. The filter holds a programmable multicast match field and a sticky match flag. A data character produces a FIFO write only while the flag is set, or while the match field is all ones. In that case addressing is bypassed and every data character is accepted.

Entering self-test clears the match flag. After self-test ends, normal traffic is blocked until a fresh address command passes the match rule. The character that carries the end-of-operation marker closes the current operation. Any later data needs a new matching address, so an operation whose address did not match is dropped in full. The FIFO write enable comes from a register and follows the accepted character by one clock.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, fifoWrEn is 0 and the match field holds all ones. A data character that follows reset without any address command is written.
- R2: An address command (charValid=1, charIsAddr=1) matches when charAddr is non-zero and every bit set in charAddr is also set in the match field. A matching command sets the flag. A non-matching command, including address 0, clears it.
- R3: While the match field is all ones, every data character is written and address commands leave acceptance unchanged, even when they would not match.
- R4: A data character (charValid=1, charIsAddr=0) seen at a rising edge raises fifoWrEn for exactly the next cycle, but only if the flag was set before that character. A flag change made by an address command applies from the next data character onward.
- R5: An address command character never produces a FIFO write.
- R6: Self-test clears the match flag. After selfTestEn returns low, data is rejected until a matching address command arrives.
- R7: fifoWrEn is 0 in every cycle that follows a cycle in which selfTestEn was 1, whatever characters arrive.
- R8: A data character with charOpEnd=1 is written if the flag is set, and it then clears the flag. The following data characters are rejected until a new matching address.
- R9: When cfgWrEn=1, the match field is loaded from cfgMatchField and the match flag is cleared.
- R10: An address command presented with charValid=0 has no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Load strobe for the match field |
| cfgMatchField | input | ADDR_W | New multicast match field value |
| charValid | input | 1 | A received character is present this cycle |
| charIsAddr | input | 1 | The present character is a serial address command |
| charAddr | input | ADDR_W | Address value carried by an address command |
| charOpEnd | input | 1 | The present data character ends its operation |
| selfTestEn | input | 1 | Self-test enable, clears the match flag |
| fifoWrEn | output | 1 | Registered receive FIFO write enable |

## Verification
The bench builds the filter with the default ADDR_W of 8. That width is wide enough to separate a subset address (0x04 inside a field of 0x0C), an address that shares some bits with the field but falls outside it (0x14), the zero address, and a field equal to the address. An 8-bit field also keeps the all-ones bypass value distinct from these partial fields. With these values the bench reaches the bypass, mismatch, exact-fit and empty-field corners, as well as the self-test and end-of-operation clearing paths.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;

  // Decoded per-cycle strobes handed from control to datapath
  typedef struct packed {
    logic cfgLoad;    // reprogram the match field
    logic addrChar;   // valid address command character
    logic dataChar;   // valid data character
    logic opClose;    // data character ending an operation
    logic testClear;  // self-test active
  } filtStrobes_t;

endpackage

// File: rtl/rx_addr_filter_ctrl.sv
module rx_addr_filter_ctrl
  import rx_addr_filter_pkg::*;
(
  input  logic         cfgWrEn,
  input  logic         charValid,
  input  logic         charIsAddr,
  input  logic         charOpEnd,
  input  logic         selfTestEn,
  output filtStrobes_t stb
);

  always_comb begin
    stb.testClear = selfTestEn;
    stb.cfgLoad   = cfgWrEn;
    stb.addrChar  = charValid & charIsAddr;
    stb.dataChar  = charValid & ~charIsAddr;
    stb.opClose   = charValid & ~charIsAddr & charOpEnd;
  end

endmodule

// File: rtl/rx_addr_filter_dp.sv
module rx_addr_filter_dp
  import rx_addr_filter_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  filtStrobes_t      stb,
  input  logic [ADDR_W-1:0] cfgMatchField,
  input  logic [ADDR_W-1:0] charAddr,
  output logic              fifoWrEn
);

  localparam logic [ADDR_W-1:0] FIELD_RESET = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] matchField;
  logic [ADDR_W-1:0] outsideBits;
  logic              matchFlag;
  logic              matchAll;
  logic              addrHit;

  // Per-bit test: an address bit set where the field is clear
  for (genvar i = 0; i < ADDR_W; i++) begin : g_outside
    assign outsideBits[i] = charAddr[i] & ~matchField[i];
  end

  assign matchAll = &matchField;
  assign addrHit  = (|charAddr) & ~(|outsideBits);

  always_ff @(posedge clk) begin
    if (!rstN)            matchField <= FIELD_RESET;
    else if (stb.cfgLoad) matchField <= cfgMatchField;
  end

  // Priority: self-test, reprogram, address command, operation end
  always_ff @(posedge clk) begin
    if (!rstN)                             matchFlag <= 1'b0;
    else if (stb.testClear)                matchFlag <= 1'b0;
    else if (stb.cfgLoad)                  matchFlag <= 1'b0;
    else if (stb.addrChar && !matchAll)    matchFlag <= addrHit;
    else if (stb.opClose)                  matchFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) fifoWrEn <= 1'b0;
    else       fifoWrEn <= stb.dataChar & ~stb.testClear & (matchAll | matchFlag);
  end

  a_r7_selftest_blocks: assert property (@(posedge clk) disable iff (!rstN)
    stb.testClear |=> !fifoWrEn);

  a_r5_addr_not_written: assert property (@(posedge clk) disable iff (!rstN)
    stb.addrChar |=> !fifoWrEn);

  a_r6_selftest_clears: assert property (@(posedge clk) disable iff (!rstN)
    stb.testClear |=> !matchFlag);

  a_r9_cfg_clears: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cfgLoad && !stb.testClear) |=> (!matchFlag && matchField == $past(cfgMatchField)));

  a_r3_all_ones_accepts: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dataChar && !stb.testClear && matchAll) |=> fifoWrEn);

  a_r8_end_closes: assert property (@(posedge clk) disable iff (!rstN)
    (stb.opClose && !stb.testClear && !stb.cfgLoad) |=> !matchFlag);

  a_r2_zero_addr_misses: assert property (@(posedge clk) disable iff (!rstN)
    (stb.addrChar && !matchAll && !stb.testClear && !stb.cfgLoad && charAddr == '0)
      |=> !matchFlag);

  a_r4_write_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    !stb.dataChar |=> !fifoWrEn);

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_addr_filter_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgMatchField,
  input  logic              charValid,
  input  logic              charIsAddr,
  input  logic [ADDR_W-1:0] charAddr,
  input  logic              charOpEnd,
  input  logic              selfTestEn,
  output logic              fifoWrEn
);

  filtStrobes_t stb;

  rx_addr_filter_ctrl i_ctrl (
    .cfgWrEn    (cfgWrEn),
    .charValid  (charValid),
    .charIsAddr (charIsAddr),
    .charOpEnd  (charOpEnd),
    .selfTestEn (selfTestEn),
    .stb        (stb)
  );

  rx_addr_filter_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .cfgMatchField (cfgMatchField),
    .charAddr      (charAddr),
    .fifoWrEn      (fifoWrEn)
  );

endmodule

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;

  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rstN;
  logic              cfgWrEn;
  logic [ADDR_W-1:0] cfgMatchField;
  logic              charValid;
  logic              charIsAddr;
  logic [ADDR_W-1:0] charAddr;
  logic              charOpEnd;
  logic              selfTestEn;
  logic              fifoWrEn;

  int testsRun  = 0;
  int testsFail = 0;

  always #10 clk = ~clk;

  rx_addr_filter #(.ADDR_W(ADDR_W)) i_rx_addr_filter (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgMatchField(cfgMatchField),
    .charValid(charValid), .charIsAddr(charIsAddr), .charAddr(charAddr),
    .charOpEnd(charOpEnd), .selfTestEn(selfTestEn), .fifoWrEn(fifoWrEn)
  );

  typedef struct packed {
    logic       cfg;
    logic [7:0] cfgVal;
    logic       vld;
    logic       adr;
    logic [7:0] addr;
    logic       opEnd;
    logic       st;
    logic       expWr;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, //  0 R1 default field
    '{1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0}, //  1 R5 addr not written
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, //  2 R3 addr ignored
    '{1'b1, 8'h0C, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, //  3 R9 load field
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, //  4 R9 flag cleared
    '{1'b0, 8'h00, 1'b1, 1'b1, 8'h04, 1'b0, 1'b0, 1'b0}, //  5 R5
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, //  6 R2 R4 subset hit
    '{1'b0, 8'h00, 1'b1, 1'b1, 8'h14, 1'b0, 1'b0, 1'b0}, //  7 R2 outside bit
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, //  8 R2 miss
    '{1'b0, 8'h00, 1'b1, 1'b1, 8'h0C, 1'b0, 1'b0, 1'b0}, //  9 R2
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // 10 R4
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1}, // 11 R8 end written
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // 12 R8 after end
    '{1'b0, 8'h00, 1'b0, 1'b1, 8'h08, 1'b0, 1'b0, 1'b0}, // 13 R10 invalid addr
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // 14 R10 no effect
    '{1'b0, 8'h00, 1'b1, 1'b1, 8'h08, 1'b0, 1'b0, 1'b0}, // 15 R2
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // 16 R4
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0}, // 17 R7 self-test
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0}, // 18 R7
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // 19 R6 blocked
    '{1'b0, 8'h00, 1'b1, 1'b1, 8'h04, 1'b0, 1'b0, 1'b0}, // 20 R6 re-match
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // 21 R6 accepted
    '{1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0}, // 22 R2 zero address
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}  // 23 R2 zero misses
  };

  task automatic check(input logic act, input logic exp, input string req);
    testsRun++;
    if (act !== exp) begin
      testsFail++;
      $display("FAIL %s: fifoWrEn=%b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    cfgWrEn = 1'b0; cfgMatchField = '0; charValid = 1'b0; charIsAddr = 1'b0;
    charAddr = '0; charOpEnd = 1'b0; selfTestEn = 1'b0;
  endtask

  task automatic drive(input logic cfg, input logic [7:0] cv, input logic vld,
                       input logic adr, input logic [7:0] a, input logic oe,
                       input logic st);
    cfgWrEn = cfg; cfgMatchField = cv; charValid = vld; charIsAddr = adr;
    charAddr = a; charOpEnd = oe; selfTestEn = st;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    testsFail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    idle();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(fifoWrEn, 1'b0, "R1 reset state");
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].cfg, VECS[i].cfgVal, VECS[i].vld, VECS[i].adr,
            VECS[i].addr, VECS[i].opEnd, VECS[i].st);
      check(fifoWrEn, VECS[i].expWr, $sformatf("vector %0d", i));
    end

    // R1: reset mid-run restores the all-ones field
    idle();
    rstN = 1'b0;
    @(negedge clk);
    check(fifoWrEn, 1'b0, "R1 reset mid-run");
    rstN = 1'b1;
    drive(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    check(fifoWrEn, 1'b1, "R1 field back to all ones");

    // R2: empty field matches nothing
    drive(1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    drive(1'b0, 8'h00, 1'b1, 1'b1, 8'h01, 1'b0, 1'b0);
    drive(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    check(fifoWrEn, 1'b0, "R2 empty field");

    // R2: address equal to field matches
    drive(1'b1, 8'h0F, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    drive(1'b0, 8'h00, 1'b1, 1'b1, 8'h0F, 1'b0, 1'b0);
    drive(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    check(fifoWrEn, 1'b1, "R2 exact field");

    // R4: pulse lasts one cycle
    drive(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    check(fifoWrEn, 1'b0, "R4 single-cycle write");

    idle();
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule